// File: doc/BRIEF.md
# Paged Address Translation Unit with Hardware Table Walker

This block turns a logical address into a physical address for paged memory. The page size is a power of two, so the upper address bits give the virtual page number and the lower bits give the byte offset. The offset is carried across unchanged, and the page number is replaced by a frame number.

Every request first looks in a small, fully associative translation cache. A hit answers on the next cycle and does not touch memory. On a miss, a hardware walker reads one entry from a single-level page table through a simple request/response memory port. It installs the mapping and then answers. The walker also enforces the page's read, write and execute rights. It maintains the referenced and dirty bits and writes a changed entry back to the table before the translation is returned.

The unit holds one request at a time. It lowers its ready output for the whole length of a walk or write-back.

States: `ST_IDLE` accepts requests and answers hits. `ST_FETCH` holds the table read until the memory responds. `ST_STORE` holds the write-back of an updated entry until the memory responds.

Transitions:
- IDLE→FETCH on a miss.
- IDLE→STORE on a hit that changes status bits.
- FETCH→STORE when a fetched, permitted entry needs its bits changed.
- FETCH→IDLE on a page fault, a protection fault or a clean fill.
- STORE→IDLE when the write completes.

Top module: `tlbw_mmu`

## Requirements
- R1: Virtual address bits 15:9 are the page number and bits 8:0 are the offset. A successful translation returns `{frame, offset}` with the offset unchanged.
- R2: A cached, permitted access that needs no status change raises `rsp_valid` on the cycle after acceptance and makes no memory request.
- R3: A miss issues one read at `pt_base + page*2`. The read request and its address are held until `mem_rsp_valid`, and the response follows on the next cycle when no write-back is due.
- R4: The page table entry layout is: bit 0 valid, bit 1 read, bit 2 write, bit 3 execute, bit 4 referenced, bit 5 dirty, bits 12:6 frame, and bits 15:13 zero.
- R5: A fetched entry with the valid bit clear gives `rsp_page_fault` with `rsp_paddr` zero. It is not cached, so a repeat of the same access walks again.
- R6: Access kinds are 0 read, 1 write, 2 execute, and 3 is never permitted. An access the entry does not permit gives `rsp_prot_fault` with `rsp_paddr` zero and leaves the table unchanged. A resident entry is still cached.
- R7: A permitted access sets the referenced bit, and a write also sets the dirty bit. If this changes the entry, the updated entry is written to the same table address before the response, which then follows on the cycle after the write's `mem_rsp_valid`.
- R8: The cache has 4 entries, and fills replace them in round-robin order, advancing one place per fill.
- R9: A one-cycle `flush` invalidates every cache entry and returns the replacement pointer to entry 0.
- R10: `req_ready` is low from acceptance of a request that needs memory until its response is issued.
- R11: After reset, `req_ready` is high, `rsp_valid` and `mem_valid` are low, and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all cached translations |
| pt_base | input | 16 | Byte address of page table entry 0 |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit can accept a request |
| req_vaddr | input | 16 | Logical address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 16 | Physical address, zero on a fault |
| rsp_page_fault | output | 1 | Page not resident |
| rsp_prot_fault | output | 1 | Access kind not permitted |
| mem_valid | output | 1 | Table access request, held until response |
| mem_write | output | 1 | Table access is a write-back |
| mem_addr | output | 16 | Table entry byte address |
| mem_wdata | output | 16 | Updated entry for a write-back |
| mem_rsp_valid | input | 1 | Memory completes the held access |
| mem_rdata | input | 16 | Entry read from the table |

## Verification
Each result has a due cycle:
- A clean hit answers at the first sample after its accepting edge.
- A fill without a write-back answers one cycle after the memory's read completion.
- Any path with a write-back answers one cycle after the write completion.

With the bench memory completing three cycles after it sees a request, the due latencies are 0, 4 or 9 cycles. The bench predicts the latency for every request from its own model of the cache and table. It then counts falling edges from acceptance until the strobe appears, so an early or late strobe shows up as a wrong count. It also counts the table reads and writes made inside that window.

// File: rtl/tlbw_pkg.sv
package tlbw_pkg;
    timeunit 1ns; timeprecision 1ps;

    localparam int unsigned OFS_W     = 9;              // 512-byte pages
    localparam int unsigned VPN_W     = 7;
    localparam int unsigned PPN_W     = 7;
    localparam int unsigned VA_W      = VPN_W + OFS_W;
    localparam int unsigned PA_W      = PPN_W + OFS_W;
    localparam int unsigned DATA_W    = 16;
    localparam int unsigned PTE_SHIFT = 1;              // two bytes per entry
    localparam int unsigned PTE_W     = PPN_W + 6;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    // valid is bit 0, frame sits at the top
    typedef struct packed {
        logic [PPN_W-1:0] frame;
        logic             dirty;
        logic             refd;
        logic             ex;
        logic             wr;
        logic             rd;
        logic             vld;
    } pte_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_STORE
    } walk_state_e;
endpackage

// File: rtl/tlbw_perm.sv
module tlbw_perm
    import tlbw_pkg::*;
(
    input  pte_t      pte_i,
    input  acc_kind_e kind_i,
    output logic      ok_o,
    output pte_t      upd_o,
    output logic      wb_o
);
    timeunit 1ns; timeprecision 1ps;

    logic right;

    always_comb begin
        unique case (kind_i)
            ACC_LOAD:  right = pte_i.rd;
            ACC_STORE: right = pte_i.wr;
            ACC_FETCH: right = pte_i.ex;
            default:   right = 1'b0;
        endcase
        ok_o        = pte_i.vld && right;
        upd_o       = pte_i;
        upd_o.refd  = 1'b1;
        if (kind_i == ACC_STORE) begin
            upd_o.dirty = 1'b1;
        end
        wb_o = ok_o && (upd_o != pte_i);
    end
endmodule

// File: rtl/tlbw_cache.sv
module tlbw_cache
    import tlbw_pkg::*;
#(
    parameter int unsigned ENTRIES = 4,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [IDX_W-1:0] lk_idx,
    output pte_t             lk_pte,
    input  logic             inst_en,
    input  logic [VPN_W-1:0] inst_vpn,
    input  pte_t             inst_pte,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  pte_t             upd_pte
);
    timeunit 1ns; timeprecision 1ps;

    logic [ENTRIES-1:0]       match;
    pte_t [ENTRIES-1:0]       ent_pte;
    logic [IDX_W-1:0]         rr_q;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic             v_q;
        logic [VPN_W-1:0] tag_q;
        pte_t             pte_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q   <= 1'b0;
                tag_q <= '0;
                pte_q <= '0;
            end else if (flush) begin
                v_q <= 1'b0;
            end else if (inst_en && rr_q == IDX_W'(g)) begin
                v_q   <= 1'b1;
                tag_q <= inst_vpn;
                pte_q <= inst_pte;
            end else if (upd_en && upd_idx == IDX_W'(g)) begin
                pte_q <= upd_pte;
            end
        end

        assign match[g]   = v_q && (tag_q == lk_vpn);
        assign ent_pte[g] = pte_q;
    end

    always_comb begin
        lk_hit = 1'b0;
        lk_idx = '0;
        lk_pte = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i] && !lk_hit) begin
                lk_hit = 1'b1;
                lk_idx = IDX_W'(i);
                lk_pte = ent_pte[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (flush) begin
            rr_q <= '0;
        end else if (inst_en) begin
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end
endmodule

// File: rtl/tlbw_mmu.sv
module tlbw_mmu
    import tlbw_pkg::*;
#(
    parameter int unsigned ENTRIES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [PA_W-1:0]   pt_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [1:0]        req_kind,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_page_fault,
    output logic              rsp_prot_fault,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [PA_W-1:0]   mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rdata
);
    timeunit 1ns; timeprecision 1ps;

    localparam int unsigned IDX_W = $clog2(ENTRIES);

    walk_state_e      state_q, state_d;
    logic [VPN_W-1:0] req_vpn, cur_vpn_q;
    logic [OFS_W-1:0] req_ofs, cur_ofs_q, fire_ofs;
    acc_kind_e        req_kind_e, cur_kind_q;
    pte_t             lk_pte, hit_upd, fet_pte, fet_upd, inst_pte, wb_pte_q, wb_pte_d;
    logic             lk_hit, hit_ok, hit_wb, fet_ok, fet_wb;
    logic [IDX_W-1:0] lk_idx;
    logic             accept, inst_en, upd_en, fire, fire_pf, fire_xf;
    logic [PPN_W-1:0] fire_frame;
    logic [PA_W-1:0]  addr_q;
    logic             unused_hi;

    assign req_vpn    = req_vaddr[VA_W-1:OFS_W];
    assign req_ofs    = req_vaddr[OFS_W-1:0];
    assign req_kind_e = acc_kind_e'(req_kind);
    assign fet_pte    = pte_t'(mem_rdata[PTE_W-1:0]);
    assign unused_hi  = ^mem_rdata[DATA_W-1:PTE_W];

    tlbw_cache #(.ENTRIES(ENTRIES)) u_cache (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .lk_vpn   (req_vpn),
        .lk_hit   (lk_hit),
        .lk_idx   (lk_idx),
        .lk_pte   (lk_pte),
        .inst_en  (inst_en),
        .inst_vpn (cur_vpn_q),
        .inst_pte (inst_pte),
        .upd_en   (upd_en),
        .upd_idx  (lk_idx),
        .upd_pte  (hit_upd)
    );

    tlbw_perm u_hit_perm (
        .pte_i (lk_pte),
        .kind_i(req_kind_e),
        .ok_o  (hit_ok),
        .upd_o (hit_upd),
        .wb_o  (hit_wb)
    );

    tlbw_perm u_fet_perm (
        .pte_i (fet_pte),
        .kind_i(cur_kind_q),
        .ok_o  (fet_ok),
        .upd_o (fet_upd),
        .wb_o  (fet_wb)
    );

    // next state and control strobes
    always_comb begin
        state_d    = state_q;
        accept     = 1'b0;
        inst_en    = 1'b0;
        inst_pte   = fet_pte;
        upd_en     = 1'b0;
        fire       = 1'b0;
        fire_pf    = 1'b0;
        fire_xf    = 1'b0;
        fire_frame = '0;
        wb_pte_d   = wb_pte_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    if (!lk_hit) begin
                        state_d = ST_FETCH;
                    end else if (!hit_ok) begin
                        fire    = 1'b1;
                        fire_xf = 1'b1;
                    end else if (hit_wb) begin
                        upd_en   = 1'b1;
                        wb_pte_d = hit_upd;
                        state_d  = ST_STORE;
                    end else begin
                        fire       = 1'b1;
                        fire_frame = lk_pte.frame;
                    end
                end
            end
            ST_FETCH: begin
                if (mem_rsp_valid) begin
                    if (!fet_pte.vld) begin
                        fire    = 1'b1;
                        fire_pf = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        inst_en  = 1'b1;
                        inst_pte = fet_ok ? fet_upd : fet_pte;
                        if (!fet_ok) begin
                            fire    = 1'b1;
                            fire_xf = 1'b1;
                            state_d = ST_IDLE;
                        end else if (fet_wb) begin
                            wb_pte_d = fet_upd;
                            state_d  = ST_STORE;
                        end else begin
                            fire       = 1'b1;
                            fire_frame = fet_pte.frame;
                            state_d    = ST_IDLE;
                        end
                    end
                end
            end
            ST_STORE: begin
                if (mem_rsp_valid) begin
                    fire       = 1'b1;
                    fire_frame = wb_pte_q.frame;
                    state_d    = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign fire_ofs = (state_q == ST_IDLE) ? req_ofs : cur_ofs_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // response and request-context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid      <= 1'b0;
            rsp_paddr      <= '0;
            rsp_page_fault <= 1'b0;
            rsp_prot_fault <= 1'b0;
            cur_vpn_q      <= '0;
            cur_ofs_q      <= '0;
            cur_kind_q     <= ACC_LOAD;
            wb_pte_q       <= '0;
            addr_q         <= '0;
        end else begin
            rsp_valid      <= fire;
            rsp_page_fault <= fire && fire_pf;
            rsp_prot_fault <= fire && fire_xf;
            if (fire) begin
                rsp_paddr <= (fire_pf || fire_xf) ? '0 : {fire_frame, fire_ofs};
            end
            if (accept) begin
                cur_vpn_q  <= req_vpn;
                cur_ofs_q  <= req_ofs;
                cur_kind_q <= req_kind_e;
                addr_q     <= pt_base + (PA_W'(req_vpn) << PTE_SHIFT);
            end
            wb_pte_q <= wb_pte_d;
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign mem_valid = (state_q != ST_IDLE);
    assign mem_write = (state_q == ST_STORE);
    assign mem_addr  = addr_q;
    assign mem_wdata = {{(DATA_W - PTE_W){1'b0}}, wb_pte_q};
endmodule

// File: rtl/tlbw_mmu_chk.sv
module tlbw_mmu_chk
    import tlbw_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_vaddr,
    input logic            rsp_valid,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            rsp_page_fault,
    input logic            rsp_prot_fault,
    input logic            mem_valid,
    input logic            mem_write,
    input logic [PA_W-1:0] mem_addr,
    input logic            mem_rsp_valid
);
    timeunit 1ns; timeprecision 1ps;

    logic [OFS_W-1:0] ofs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      ofs_q <= '0;
        else if (req_valid && req_ready) ofs_q <= req_vaddr[OFS_W-1:0];
    end

    AST_FAULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_page_fault && rsp_prot_fault)); // R6

    AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_page_fault || rsp_prot_fault)) |-> (rsp_paddr == '0)); // R5

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_page_fault && !rsp_prot_fault) |-> (rsp_paddr[OFS_W-1:0] == ofs_q)); // R1

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !req_ready); // R10

    AST_MEM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_rsp_valid) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write))); // R3

    AST_RSP_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(req_valid && req_ready) || $past(mem_rsp_valid))); // R2
endmodule

bind tlbw_mmu tlbw_mmu_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .rsp_valid     (rsp_valid),
    .rsp_paddr     (rsp_paddr),
    .rsp_page_fault(rsp_page_fault),
    .rsp_prot_fault(rsp_prot_fault),
    .mem_valid     (mem_valid),
    .mem_write     (mem_write),
    .mem_addr      (mem_addr),
    .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/tlbw_mmu_test.sv
module tlbw_mmu_test;
    timeunit 1ns; timeprecision 1ps;

    localparam int          MEM_LAT = 3;
    localparam logic [15:0] PT_BASE = 16'h4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_ready, rsp_valid, rsp_page_fault, rsp_prot_fault;
    logic [15:0] rsp_paddr;
    logic        mem_valid, mem_write;
    logic [15:0] mem_addr, mem_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [15:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int n_rd = 0;
    int n_wr = 0;
    logic [15:0] last_addr = '0;

    logic [15:0] ptm  [128];   // table as held by the memory
    logic [15:0] pexp [128];   // table as the bench expects it
    logic [6:0]  mtag [4];
    bit          mval [4];
    int          mrr = 0;

    always #10 clk = ~clk;     // 20 ns period, 50 MHz

    tlbw_mmu uut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .pt_base(PT_BASE),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_kind(req_kind),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_page_fault(rsp_page_fault), .rsp_prot_fault(rsp_prot_fault),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata)
    );

    // table memory: completes MEM_LAT falling edges after it sees a request
    initial begin
        logic [15:0] off;
        forever begin
            @(negedge clk);
            if (rst_n && mem_valid) begin
                repeat (MEM_LAT) @(negedge clk);
                off       = (mem_addr - PT_BASE) >> 1;
                last_addr = mem_addr;
                if (mem_write) begin
                    n_wr++;
                    ptm[off[6:0]] = mem_wdata;
                end else begin
                    n_rd++;
                    mem_rdata = ptm[off[6:0]];
                end
                mem_rsp_valid = 1'b1;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // R4 entry layout
    function automatic logic [15:0] mk(input int frame, input bit v, input bit r, input bit w,
                                       input bit x, input bit a, input bit d);
        return {3'b000, 7'(frame), d, a, x, w, r, v};
    endfunction

    function automatic bit allowed(input logic [15:0] p, input logic [1:0] k);
        case (k)
            2'd0:    return p[0] & p[1];
            2'd1:    return p[0] & p[2];
            2'd2:    return p[0] & p[3];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [15:0] touched(input logic [15:0] p, input logic [1:0] k);
        return p | 16'h0010 | ((k == 2'd1) ? 16'h0020 : 16'h0000);
    endfunction

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        for (int i = 0; i < 4; i++) mval[i] = 1'b0;
        mrr = 0;
    endtask

    task automatic do_req(input logic [15:0] va, input logic [1:0] kind, input string tag);
        logic [6:0]  vpn;
        logic [15:0] p, u;
        bit          hit, epf, exf, wb, not_busy;
        logic [15:0] epa;
        int          erd, ewr, elat, lat, rd0, wr0;
        vpn = va[15:9];
        hit = 1'b0;
        for (int i = 0; i < 4; i++) if (mval[i] && mtag[i] == vpn) hit = 1'b1;
        p   = pexp[vpn];
        erd = hit ? 0 : 1;
        ewr = 0;
        epf = 1'b0;
        exf = 1'b0;
        wb  = 1'b0;
        epa = 16'h0000;
        if (!hit && p[0]) begin
            mtag[mrr] = vpn;
            mval[mrr] = 1'b1;
            mrr = (mrr + 1) % 4;
        end
        if (!p[0]) begin
            epf = 1'b1;
        end else if (!allowed(p, kind)) begin
            exf = 1'b1;
        end else begin
            u   = touched(p, kind);
            wb  = (u != p);
            epa = {p[12:6], va[8:0]};
            if (wb) begin
                ewr = 1;
                pexp[vpn] = u;
            end
        end
        if (hit) elat = wb ? MEM_LAT + 1 : 0;
        else     elat = wb ? 2 * MEM_LAT + 3 : MEM_LAT + 1;

        @(negedge clk);
        chk(req_ready === 1'b1, {tag, " R10 idle before request"}, int'(req_ready), 1);
        rd0 = n_rd;
        wr0 = n_wr;
        req_valid = 1'b1;
        req_vaddr = va;
        req_kind  = kind;
        @(posedge clk);
        #1 req_valid = 1'b0;
        lat = 0;
        not_busy = 1'b0;
        forever begin
            @(negedge clk);
            if (rsp_valid) break;
            if (req_ready) not_busy = 1'b1;
            lat++;
            if (lat > 300) break;
        end
        chk(rsp_paddr === epa && rsp_page_fault === epf && rsp_prot_fault === exf,
            {tag, " paddr/faults"}, int'({rsp_page_fault, rsp_prot_fault, rsp_paddr}),
            int'({epf, exf, epa}));
        chk(lat == elat, {tag, " latency"}, lat, elat);
        chk(n_rd - rd0 == erd && n_wr - wr0 == ewr, {tag, " table reads/writes"},
            (n_rd - rd0) * 16 + (n_wr - wr0), erd * 16 + ewr);
        chk(!not_busy, {tag, " R10 ready low while walking"}, int'(not_busy), 0);
        chk(ptm[vpn] === pexp[vpn], {tag, " R7 table entry"}, int'(ptm[vpn]), int'(pexp[vpn]));
        if (erd + ewr > 0)
            chk(last_addr === PT_BASE + {8'h00, vpn, 1'b0}, {tag, " R3 entry address"},
                int'(last_addr), int'(PT_BASE + {8'h00, vpn, 1'b0}));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 128; i++) begin
            rv = $urandom;
            ptm[i] = mk(int'(rv[6:0]), rv[10:8] != 3'd0, rv[11], rv[12], rv[13], rv[14], rv[15]);
            pexp[i] = ptm[i];
        end
        // directed pages
        ptm[2]  = mk(5, 1, 1, 1, 0, 1, 0);
        ptm[5]  = mk(3, 1, 1, 1, 1, 1, 1);
        ptm[9]  = mk(4, 0, 1, 1, 1, 1, 1);
        ptm[10] = mk(7, 1, 1, 0, 0, 1, 0);
        ptm[11] = mk(12, 1, 1, 1, 0, 0, 0);
        for (int i = 20; i < 25; i++) ptm[i] = mk(i + 40, 1, 1, 0, 0, 1, 0);
        for (int i = 0; i < 128; i++) pexp[i] = ptm[i];
        for (int i = 0; i < 4; i++) mval[i] = 1'b0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_valid === 1'b0,
            "R11 reset outputs", int'({req_ready, rsp_valid, mem_valid}), 3'b100);

        do_req(16'd1200, 2'd0, "R1 R3 R4 miss fill");
        chk(rsp_paddr === 16'd2736, "R1 example 1200", int'(rsp_paddr), 2736);
        do_req(16'd1200, 2'd0, "R2 hit");
        do_req(16'd3000, 2'd0, "R1 R3 second example");
        chk(rsp_paddr === 16'd1976, "R1 example 3000", int'(rsp_paddr), 1976);
        do_req(16'd3001, 2'd1, "R2 write hit no change");

        do_req({7'd9, 9'd12}, 2'd0, "R5 not resident");
        do_req({7'd9, 9'd12}, 2'd0, "R5 fault walks again");

        do_req({7'd10, 9'd40}, 2'd1, "R6 write refused");
        do_req({7'd10, 9'd41}, 2'd2, "R6 exec refused");
        do_req({7'd10, 9'd42}, 2'd3, "R6 reserved kind");
        do_req({7'd10, 9'd43}, 2'd0, "R6 read allowed");

        do_req({7'd11, 9'd7}, 2'd0, "R7 miss sets referenced");
        do_req({7'd11, 9'd8}, 2'd1, "R7 hit sets dirty");
        do_req({7'd11, 9'd9}, 2'd1, "R7 hit already dirty");

        do_req(16'd1200, 2'd0, "R9 before flush");
        do_flush();
        do_req(16'd1200, 2'd0, "R9 miss after flush");

        do_flush();
        for (int i = 20; i < 25; i++) do_req({7'(i), 9'd1}, 2'd0, "R8 fill");
        do_req({7'd21, 9'd2}, 2'd0, "R8 survivor hits");
        do_req({7'd20, 9'd3}, 2'd0, "R8 oldest evicted");
        do_req({7'd22, 9'd4}, 2'd0, "R8 survivor hits");
        do_req({7'd21, 9'd5}, 2'd0, "R8 next victim evicted");

        for (int n = 0; n < 400; n++) begin
            rv = $urandom;
            if (rv[31:26] == 6'd0) do_flush();
            do_req({3'b000, rv[3:0], rv[20:12]}, rv[5:4], "R1 R2 R3 R5 R6 R7 R8 random");
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule